// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address presented to an SDRAM device on every clock of a read or write burst. A controller pulses a start input together with the starting column, the burst length code and the ordering select. Beginning on the following clock, the block emits one column per cycle with a valid flag. A last-beat flag marks the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size. Sequential order counts up and wraps within the block. Interleaved order XORs the beat index into the low column bits. Full-page bursts step through every column of the row and wrap at the top. They end only when the controller asserts the stop input, which it does for a burst-stop or a precharge command. A new start may arrive on any cycle. It replaces whatever burst is running, and it overrides a stop in the same cycle.

Top module: `sdram_colgen`

## Requirements
- R1: After reset, and whenever no burst is active, valid_o and last_o are 0 and col_o is 0.
- R2: A start_i pulse on any cycle makes the next cycle show valid_o=1 with col_o equal to start_col_i as beat 0. This discards any burst in progress, and start_i wins over stop_i in the same cycle.
- R3: blen_i codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. A fixed burst holds valid_o high for exactly that many cycles and then drops it.
- R4: With ilv_i=0 (sequential), beat b of an N-beat burst from column s is (s with its low log2(N) bits replaced by (s+b) mod N). The upper bits are unchanged.
- R5: With ilv_i=1 (interleaved), beat b of an N-beat burst is s XOR b, where b only touches the low log2(N) bits.
- R6: Any blen_i code with bit 2 set selects a full page. Beat b is (s+b) mod 2^COL_W regardless of ilv_i, the burst runs until stopped, and last_o stays 0.
- R7: last_o is 1 exactly on beat N-1 of a fixed burst and 0 on every other cycle.
- R8: stop_i without start_i ends an active burst: on the next cycle valid_o and last_o are 0. While idle, stop_i has no effect.
- R9: A 1-beat burst gives exactly one valid cycle at the start column, with last_o asserted on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load a new burst this cycle |
| start_col_i | input | COL_W | Starting column of the new burst |
| blen_i | input | 3 | Burst length code (0..3 fixed, bit 2 full page) |
| ilv_i | input | 1 | 1 interleaved order, 0 sequential |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | A burst beat is presented |
| last_o | output | 1 | Final beat of a fixed burst |

## Verification
A corrupted beat counter shows up as a wrong column on the very next beat. It also moves last_o off beat N-1, which lengthens or shortens the valid window by one or more cycles. A wrong latched base or ordering bit gives a wrong column from beat 0 or beat 1 onward. A sticky active state shows as valid_o staying high one cycle past the last beat or past a stop. Because of this, the bench compares every beat of every burst against an arithmetic model, so any such fault is caught within one clock of where it arises.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;
   // burst length codes; any code with bit 2 set means full page
   typedef enum logic [2:0] {
      BLEN_1    = 3'd0,
      BLEN_2    = 3'd1,
      BLEN_4    = 3'd2,
      BLEN_8    = 3'd3,
      BLEN_PAGE = 3'd7
   } blen_e;

   localparam int unsigned MAX_FIXED_LOG2 = 3;

   function automatic logic is_page(input logic [2:0] code);
      return code[2];
   endfunction
endpackage

// File: rtl/sdram_colgen_ctr.sv
module sdram_colgen_ctr
   import sdram_colgen_pkg::*;
#(
   parameter int unsigned COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             stop_i,
   input  logic [2:0]       blen_i,
   output logic [COL_W-1:0] beat_o,
   output logic [2:0]       blen_o,
   output logic             active_o,
   output logic             last_o
);
   logic [COL_W-1:0] beat_q;
   logic [2:0]       blen_q;
   logic             active_q;
   logic [COL_W-1:0] final_beat;

   // N-1 for a fixed length of 2^blen_q[1:0]
   assign final_beat = COL_W'((1 << blen_q[1:0]) - 1);
   assign last_o     = active_q & ~is_page(blen_q) & (beat_q == final_beat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q   <= '0;
         blen_q   <= 3'd0;
         active_q <= 1'b0;
      end else if (load_i) begin
         beat_q   <= '0;
         blen_q   <= blen_i;
         active_q <= 1'b1;
      end else if (stop_i || last_o) begin
         beat_q   <= '0;
         active_q <= 1'b0;
      end else if (active_q) begin
         beat_q   <= beat_q + 1'b1;
      end
   end

   assign beat_o   = beat_q;
   assign blen_o   = blen_q;
   assign active_o = active_q;
endmodule

// File: rtl/sdram_colgen_addr.sv
module sdram_colgen_addr
   import sdram_colgen_pkg::*;
#(
   parameter int unsigned COL_W  = 10,
   parameter bit          ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [2:0]       blen_i,
   input  logic             ilv_i,
   output logic [COL_W-1:0] col_o
);
   logic             page;
   logic             use_ilv;
   logic [COL_W-1:0] in_blk;
   logic [COL_W-1:0] sum;
   logic [COL_W-1:0] seq_col;
   logic [COL_W-1:0] ilv_col;

   assign page = is_page(blen_i);
   assign sum  = base_i + beat_i;

   generate
      if (ILV_EN) begin : g_ilv
         assign use_ilv = ilv_i & ~page;
      end else begin : g_seq_only
         assign use_ilv = 1'b0;
      end

      for (genvar i = 0; i < COL_W; i++) begin : g_bit
         if (i < MAX_FIXED_LOG2) begin : g_low
            assign in_blk[i] = page | (blen_i[1:0] > 2'(i));
         end else begin : g_high
            assign in_blk[i] = page;
         end
         assign seq_col[i] = in_blk[i] ? sum[i] : base_i[i];
         assign ilv_col[i] = in_blk[i] ? (base_i[i] ^ beat_i[i]) : base_i[i];
      end
   endgenerate

   assign col_o = use_ilv ? ilv_col : seq_col;
endmodule

// File: rtl/sdram_colgen.sv
module sdram_colgen
   import sdram_colgen_pkg::*;
#(
   parameter int unsigned COL_W  = 10,
   parameter bit          ILV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       blen_i,
   input  logic             ilv_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);
   generate
      if (COL_W < MAX_FIXED_LOG2 || COL_W > 16) begin : g_bad_width
         $error("sdram_colgen: COL_W must lie in 3..16");
      end
   endgenerate

   logic [COL_W-1:0] base_q;
   logic             ilv_q;
   logic [COL_W-1:0] beat;
   logic [2:0]       blen_q;
   logic             active;
   logic [COL_W-1:0] col_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         ilv_q  <= 1'b0;
      end else if (start_i) begin
         base_q <= start_col_i;
         ilv_q  <= ilv_i;
      end
   end

   sdram_colgen_ctr #(.COL_W(COL_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start_i),
      .stop_i   (stop_i),
      .blen_i   (blen_i),
      .beat_o   (beat),
      .blen_o   (blen_q),
      .active_o (active),
      .last_o   (last_o)
   );

   sdram_colgen_addr #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_addr (
      .base_i (base_q),
      .beat_i (beat),
      .blen_i (blen_q),
      .ilv_i  (ilv_q),
      .col_o  (col_raw)
   );

   assign col_o   = active ? col_raw : '0;
   assign valid_o = active;
endmodule

// File: rtl/sdram_colgen_chk.sv
module sdram_colgen_chk #(
   parameter int unsigned COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o
);
   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (valid_o && col_o == $past(start_col_i)));

   // R8
   stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !start_i) |=> (!valid_o && !last_o));

   // R7
   last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   // R3
   burst_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && !start_i) |=> !valid_o);

   // R3
   burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !last_o && !stop_i) |=> valid_o);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (col_o == '0 && !last_o));
endmodule

bind sdram_colgen sdram_colgen_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o)
);

// File: tb/sdram_colgen_bench.sv
`timescale 1ns/1ps
module sdram_colgen_bench;
   localparam int COL_W = 10;
   localparam int NCOL  = 1 << COL_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       blen_i = 3'd0;
   logic             ilv_i = 1'b0;
   logic             stop_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sdram_colgen #(.COL_W(COL_W)) u_sdram_colgen (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
      .blen_i(blen_i), .ilv_i(ilv_i), .stop_i(stop_i),
      .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
   );

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   function automatic int exp_col(input int s, input int b, input int n, input bit il);
      if (il) return s ^ b;
      return (s & ~(n - 1)) | ((s + b) & (n - 1));
   endfunction

   // drive a start at a falling edge; returns at the falling edge showing beat 0
   task automatic kick(input int s, input int code, input bit il, input bit stp);
      start_i = 1'b1; start_col_i = COL_W'(s); blen_i = 3'(code); ilv_i = il; stop_i = stp;
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
   endtask

   task automatic run_fixed(input int s, input int code, input bit il);
      int n;
      n = 1 << code;
      kick(s, code, il, 1'b0);
      for (int b = 0; b < n; b++) begin
         chk("R3 valid", int'(valid_o), 1);
         chk(il ? "R5 col" : "R4 col", int'(col_o), exp_col(s, b, n, il));
         if (n == 1) chk("R9 last", int'(last_o), 1);
         else        chk("R7 last", int'(last_o), (b == n - 1) ? 1 : 0);
         @(negedge clk);
      end
      chk("R3 end valid", int'(valid_o), 0);
      chk("R1 idle col", int'(col_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset valid", int'(valid_o), 0);
      chk("R1 reset last", int'(last_o), 0);
      chk("R1 reset col", int'(col_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep fixed lengths, both orders, low and high start columns
      for (int code = 0; code < 4; code++)
         for (int il = 0; il < 2; il++)
            for (int k = 0; k < 24; k++)
               run_fixed((k < 16) ? k : (NCOL - 24 + k), code, il[0]);

      // R6 full page wraps past the top, ignores ilv, no last
      kick(NCOL - 4, 7, 1'b1, 1'b0);
      for (int b = 0; b < 12; b++) begin
         chk("R6 col", int'(col_o), (NCOL - 4 + b) % NCOL);
         chk("R6 last", int'(last_o), 0);
         chk("R6 valid", int'(valid_o), 1);
         @(negedge clk);
      end
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk("R8 page stop", int'(valid_o), 0);

      // R6 a different page code also counts as full page
      kick(500, 4, 1'b0, 1'b0);
      for (int b = 0; b < 20; b++) begin
         chk("R6 code4 col", int'(col_o), 500 + b);
         @(negedge clk);
      end
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk("R8 stop", int'(valid_o), 0);

      // R2 restart mid-burst
      kick(0, 3, 1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      chk("R4 pre-restart", int'(col_o), 2);
      kick(101, 2, 1'b0, 1'b0);
      chk("R2 restart col", int'(col_o), 101);
      for (int b = 1; b < 4; b++) begin
         @(negedge clk);
         chk("R2 restart follow", int'(col_o), exp_col(101, b, 4, 1'b0));
      end
      chk("R7 restart last", int'(last_o), 1);
      @(negedge clk);
      chk("R3 restart end", int'(valid_o), 0);

      // R2 start wins over stop in the same cycle
      kick(64, 3, 1'b0, 1'b1);
      chk("R2 start over stop valid", int'(valid_o), 1);
      chk("R2 start over stop col", int'(col_o), 64);
      @(negedge clk);
      chk("R2 start over stop beat1", int'(col_o), 65);

      // R8 stop during fixed burst
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk("R8 fixed stop valid", int'(valid_o), 0);
      chk("R8 fixed stop last", int'(last_o), 0);

      // R8 stop while idle does nothing
      stop_i = 1'b1;
      repeat (3) @(negedge clk);
      stop_i = 1'b0;
      chk("R8 idle stop valid", int'(valid_o), 0);
      chk("R8 idle stop col", int'(col_o), 0);
      run_fixed(9, 2, 1'b1);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: got 1 expected 0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule